// File: doc/BRIEF.md
# Dual-Channel Capture/Compare Timer Slice

This block pairs two timer channels around one free-running counter. Each channel can record the counter value when its input pin changes (input capture). It can also act on its output pin when the counter reaches a programmed value (output compare). With overflow steering added, the output becomes a pulse-width waveform. Software reaches the block through a single-cycle register bus. It holds the counter with a stop input and forces it to zero with a clear input. Each channel has one interrupt request line.

Each channel has an event flag. The flag can only be cleared by a read that sees it set, followed by a write of zero. A new event that arrives between those two accesses cancels the clear. Channel 0 has an extra buffered mode. In that mode it takes over channel 1's value register as a second compare slot and releases channel 1's pin. The compare value then in force is replaced only at a counter wrap, so the waveform never glitches mid-period.

Top module: `tmr_pair`

## Requirements
- R1: The counter reads 0 while `cnt_clr` is high. It keeps its value while `cnt_stop` is high and `cnt_clr` is low. Otherwise it adds one per cycle and wraps from all-ones to 0; that wrap is the overflow.
- R2: Register map: address 0 and address 2 are the control bytes of channels 0 and 1; addresses 1 and 3 are their value registers; address 4 reads the counter. Control bits: 7 event flag, 6 interrupt enable, 5 buffered select (channel 0 only), 4 mode select, 1:0 edge/action select. Reset clears every control field.
- R3: With edge/action select non-zero and mode select 0, the channel captures. After a two-flop synchronizer, select 01 reacts to a rising pin edge, 10 to a falling edge and 11 to either. On that edge the counter value is stored in the value register and the flag sets. The pin output enable stays low.
- R4: The flag clears only when a write of 0 to bit 7 follows a read that saw the flag at 1. A write of 0 without that read, a write of 1, or an event between the read and the write leaves the flag at 1.
- R5: A channel's `irq` bit is high exactly while its flag and its interrupt enable are both 1.
- R6: With edge/action select non-zero and mode select 1, the channel compares. When the counter advances while equal to the compare value, the flag sets and the output acts: 01 toggles, 10 drives 0, 11 drives 1. The pin output enable is high.
- R7: In compare operation, an overflow drives the output to 1 for select 10 and to 0 for select 11. It leaves select 01 alone. A match in the same cycle takes priority.
- R8: With edge/action select 00 the channel releases its pin (output enable low). The output level follows the inverse of mode select: 1 gives low, 0 gives high.
- R9: Channel 0's buffered select with a non-zero edge/action select runs compare operation whatever the mode select. It also disables channel 1: channel 1's control byte reads 0, ignores writes, and its pin enable and `irq` stay low.
- R10: In buffered operation, the compare value in force is loaded from whichever value register (address 1 or 3) was written last. The load happens at each overflow and on every cycle while the counter is held clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_stop | input | 1 | Freezes the counter |
| cnt_clr | input | 1 | Holds the counter at zero |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| pin_i | input | 2 | Channel pin inputs |
| pin_o | output | 2 | Channel pin output levels |
| pin_oe | output | 2 | Channel owns its pin when high |
| irq | output | 2 | Per-channel interrupt requests |

## Verification
The checks assume that mode and edge/action fields change only while the counter is both stopped and cleared. This keeps any match, overflow or capture from coinciding with a mode switch. The bench therefore reprograms channels only with `cnt_stop` and `cnt_clr` high, and releases them afterwards. The properties also assume one bus access per cycle and pin inputs that stay stable for several clocks. The stimulus changes `pin_i` only on falling clock edges and waits at least five cycles between transitions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Bit positions inside a channel control byte.
  localparam int FLAG_B = 7;
  localparam int IE_B   = 6;
  localparam int MB_B   = 5;
  localparam int MA_B   = 4;
  localparam int EL_LSB = 0;

  // Edge/action select: capture edge or compare action, by operation.
  typedef enum logic [1:0] {
    EL_OFF      = 2'b00,
    EL_RISE_TOG = 2'b01,
    EL_FALL_CLR = 2'b10,
    EL_BOTH_SET = 2'b11
  } el_t;

  typedef struct packed {
    logic flag;
    logic ie;
    logic mb;
    logic ma;
    el_t  el;
  } ctrl_f_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    run_o = ~stop_i & ~clr_i;
    ovf_o = run_o & (cnt_q == {CNT_W{1'b1}});
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (run_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_cnt_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_cmpbuf.sv
module tmr_cmpbuf #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr0_i,
  input  logic             wr1_i,
  input  logic [CNT_W-1:0] val0_i,
  input  logic [CNT_W-1:0] val1_i,
  input  logic             cnt_clr_i,
  input  logic             cnt_ovf_i,
  output logic [CNT_W-1:0] act_o
);
  logic             sel_q, sel_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             load;

  always_comb begin
    sel_d = sel_q;
    if (wr1_i)      sel_d = 1'b1;
    else if (wr0_i) sel_d = 1'b0;
    load  = cnt_clr_i | cnt_ovf_i;
    act_d = act_q;
    if (load) act_d = sel_q ? val1_i : val0_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      act_q <= '0;
    end else begin
      sel_q <= sel_d;
      act_q <= act_d;
    end
  end

  assign act_o = act_q;

  assert_act_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(cnt_clr_i || cnt_ovf_i));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit HAS_MB = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_run_i,
  input  logic             cnt_ovf_i,
  input  logic             ctrl_wr_i,
  input  logic             ctrl_rd_i,
  input  ctrl_f_t          ctrl_wf_i,
  input  logic             val_wr_i,
  input  logic [CNT_W-1:0] val_wd_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [7:0]       ctrl_o,
  output logic [CNT_W-1:0] val_o,
  input  logic             pin_i,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             irq_o
);
  logic flag_q, flag_d, ie_q, ie_d, mb_q, mb_d, ma_q, ma_d;
  logic armed_q, armed_d, out_q, out_d;
  el_t  el_q, el_d;
  logic [CNT_W-1:0] val_q, val_d;
  logic sync1_q, sync2_q, prev_q;

  el_t  el_e;
  logic ie_e, mb_e, ma_e, flag_e, wr_ok;
  logic linked, cap_mode, cmp_mode, rise, fall, cap_hit, match, evt;

  // Effective fields: a disabled channel behaves as fully reset.
  always_comb begin
    el_e   = en_i ? el_q : EL_OFF;
    ie_e   = en_i & ie_q;
    ma_e   = en_i & ma_q;
    mb_e   = en_i & HAS_MB & mb_q;
    flag_e = en_i & flag_q;
    wr_ok  = ctrl_wr_i & en_i;

    linked   = (el_e != EL_OFF);
    cap_mode = linked & ~ma_e & ~mb_e;
    cmp_mode = linked & (ma_e | mb_e);
    rise     = sync2_q & ~prev_q;
    fall     = ~sync2_q & prev_q;
    cap_hit  = cap_mode & ((el_e[0] & rise) | (el_e[1] & fall));
    match    = cmp_mode & cnt_run_i & (cnt_i == cmp_i);
    evt      = cap_hit | match;
  end

  // Control fields and flag interlock.
  always_comb begin
    ie_d  = ie_q;
    mb_d  = mb_q;
    ma_d  = ma_q;
    el_d  = el_q;
    if (wr_ok) begin
      ie_d = ctrl_wf_i.ie;
      mb_d = HAS_MB & ctrl_wf_i.mb;
      ma_d = ctrl_wf_i.ma;
      el_d = ctrl_wf_i.el;
    end

    flag_d = flag_q;
    if (evt)                                   flag_d = 1'b1;
    else if (wr_ok && armed_q && !ctrl_wf_i.flag) flag_d = 1'b0;

    armed_d = armed_q;
    if (evt || wr_ok)                          armed_d = 1'b0;
    else if (ctrl_rd_i && en_i && flag_q)      armed_d = 1'b1;
  end

  // Value register and output level.
  always_comb begin
    val_d = val_q;
    if (cap_hit)       val_d = cnt_i;
    else if (val_wr_i) val_d = val_wd_i;

    out_d = out_q;
    if (!linked) begin
      out_d = ~ma_e;
    end else if (cmp_mode) begin
      if (match) begin
        case (el_e)
          EL_RISE_TOG: out_d = ~out_q;
          EL_FALL_CLR: out_d = 1'b0;
          EL_BOTH_SET: out_d = 1'b1;
          default:     out_d = out_q;
        endcase
      end else if (cnt_ovf_i) begin
        if (el_e == EL_FALL_CLR)      out_d = 1'b1;
        else if (el_e == EL_BOTH_SET) out_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      mb_q    <= 1'b0;
      ma_q    <= 1'b0;
      el_q    <= EL_OFF;
      armed_q <= 1'b0;
      out_q   <= 1'b0;
      val_q   <= '0;
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      ie_q    <= ie_d;
      mb_q    <= mb_d;
      ma_q    <= ma_d;
      el_q    <= el_d;
      armed_q <= armed_d;
      out_q   <= out_d;
      val_q   <= val_d;
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign ctrl_o   = {flag_e, ie_e, mb_e, ma_e, 2'b00, el_e};
  assign val_o    = val_q;
  assign pin_o    = out_q;
  assign pin_oe_o = cmp_mode;
  assign irq_o    = flag_e & ie_e;

  // R3 and R6: the flag only rises after a capture or a compare match.
  assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cap_hit || match));
  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(ctrl_wr_i && en_i && armed_q && !ctrl_wf_i.flag));
  assert_capture_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_mode |-> !pin_oe_o);
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (!pin_oe_o && !irq_o && (ctrl_o == 8'h00)));
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_stop,
  input  logic              cnt_clr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [1:0]        pin_i,
  output logic [1:0]        pin_o,
  output logic [1:0]        pin_oe,
  output logic [1:0]        irq
);
  localparam int NCH = 2;
  localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(2 * NCH);

  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [CNT_W-1:0] cnt, act_cmp;
  logic             cnt_run, cnt_ovf;
  ctrl_f_t          wf;
  logic [NCH-1:0]   ctrl_wr, ctrl_rd, val_wr, ch_en;
  logic [7:0]       ctrl_rd_v [NCH];
  logic [CNT_W-1:0] val_v [NCH];
  logic [CNT_W-1:0] cmp_v [NCH];
  logic             buffered;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_q), .stop_i(cnt_stop), .clr_i(cnt_clr),
    .cnt_o(cnt), .run_o(cnt_run), .ovf_o(cnt_ovf)
  );

  always_comb begin
    wf.flag = bus_wdata[FLAG_B];
    wf.ie   = bus_wdata[IE_B];
    wf.mb   = bus_wdata[MB_B];
    wf.ma   = bus_wdata[MA_B];
    wf.el   = el_t'(bus_wdata[EL_LSB +: 2]);
    buffered = ctrl_rd_v[0][MB_B];
    ch_en    = {~buffered, 1'b1};
    cmp_v[0] = buffered ? act_cmp : val_v[0];
    cmp_v[1] = val_v[1];
  end

  tmr_cmpbuf #(.CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_s_q), .wr0_i(val_wr[0]), .wr1_i(val_wr[1]),
    .val0_i(val_v[0]), .val1_i(val_v[1]), .cnt_clr_i(cnt_clr),
    .cnt_ovf_i(cnt_ovf), .act_o(act_cmp)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ctrl_wr[i] = bus_wr & (bus_addr == ADDR_W'(2 * i));
    assign ctrl_rd[i] = bus_rd & (bus_addr == ADDR_W'(2 * i));
    assign val_wr[i]  = bus_wr & (bus_addr == ADDR_W'(2 * i + 1));

    tmr_channel #(.CNT_W(CNT_W), .HAS_MB(i == 0)) u_ch (
      .clk(clk), .rst_n(rst_s_q), .en_i(ch_en[i]),
      .cnt_i(cnt), .cnt_run_i(cnt_run), .cnt_ovf_i(cnt_ovf),
      .ctrl_wr_i(ctrl_wr[i]), .ctrl_rd_i(ctrl_rd[i]), .ctrl_wf_i(wf),
      .val_wr_i(val_wr[i]), .val_wd_i(bus_wdata), .cmp_i(cmp_v[i]),
      .ctrl_o(ctrl_rd_v[i]), .val_o(val_v[i]),
      .pin_i(pin_i[i]), .pin_o(pin_o[i]), .pin_oe_o(pin_oe[i]), .irq_o(irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CNT_ADDR) begin
      bus_rdata = cnt;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (bus_addr == ADDR_W'(2 * i))     bus_rdata = {{(CNT_W-8){1'b0}}, ctrl_rd_v[i]};
        if (bus_addr == ADDR_W'(2 * i + 1)) bus_rdata = val_v[i];
      end
    end
  end

  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_s_q)
    irq[0] |-> (ctrl_rd_v[0][FLAG_B] && ctrl_rd_v[0][IE_B]));
endmodule

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n, cnt_stop, cnt_clr, bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [1:0]  pin_i, pin_o, pin_oe, irq;
  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] d, c1, c2;

  always #10 clk = ~clk;

  tmr_pair u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_stop(cnt_stop), .cnt_clr(cnt_clr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .irq(irq)
  );

  // {edge select[1:0], starting pin level, flag expected}
  localparam logic [3:0] CAP_VEC [6] = '{
    4'b01_0_1, 4'b01_1_0, 4'b10_0_0, 4'b10_1_1, 4'b11_0_1, 4'b11_1_1
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Let the counter run until it shows t, then stop it there.
  task automatic wait_cnt(input logic [15:0] t);
    bit hit;
    @(negedge clk);
    cnt_stop = 1'b0;
    bus_addr = 3'd4;
    idle(2);
    hit = 1'b0;
    while (!hit) begin
      @(negedge clk);
      #1;
      if (bus_rdata == t) begin
        cnt_stop = 1'b1;
        hit = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_stop = 1'b1; cnt_clr = 1'b1;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; pin_i = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // Reset state (R2, R5, R8)
    rd(3'd0, d); chk("R2 ch0 ctrl reset", d, 16'h0000);
    rd(3'd2, d); chk("R2 ch1 ctrl reset", d, 16'h0000);
    rd(3'd4, d); chk("R1 counter reset", d, 16'h0000);
    chk("R8 pins released", {14'b0, pin_oe}, 16'h0000);
    chk("R8 idle level high", {14'b0, pin_o}, 16'h0003);
    chk("R5 irq reset", {14'b0, irq}, 16'h0000);

    // Capture edge selection table (R3), counter held
    for (int k = 0; k < 6; k++) begin
      pin_i[0] = CAP_VEC[k][1];
      idle(4);
      rd(3'd0, d);
      wr(3'd0, {14'b0, CAP_VEC[k][3:2]});
      pin_i[0] = ~CAP_VEC[k][1];
      idle(5);
      rd(3'd0, d);
      chk($sformatf("R3 edge vector %0d flag", k), {15'b0, d[7]}, {15'b0, CAP_VEC[k][0]});
      chk("R3 capture leaves pin", {15'b0, pin_oe[0]}, 16'h0000);
    end

    // Counter behaviour (R1) and captured value (R3)
    rd(3'd0, d);
    wr(3'd0, 16'h0001);
    cnt_clr = 1'b0; cnt_stop = 1'b0;
    idle(50);
    cnt_stop = 1'b1;
    rd(3'd4, c1);
    idle(5);
    rd(3'd4, c2);
    chk("R1 stopped counter holds", c2, c1);
    chk("R1 counter advanced", {15'b0, (c1 > 16'd40)}, 16'h0001);
    pin_i[0] = 1'b1;
    idle(5);
    rd(3'd1, d); chk("R3 captured value", d, c1);
    rd(3'd0, d); chk("R3 flag after capture", {15'b0, d[7]}, 16'h0001);
    cnt_clr = 1'b1;
    idle(2);
    rd(3'd4, d); chk("R1 clear forces zero", d, 16'h0000);

    // Flag interlock (R4) and interrupt (R5)
    wr(3'd0, 16'h00C1);
    idle(1);
    chk("R5 irq with flag and enable", {15'b0, irq[0]}, 16'h0001);
    wr(3'd0, 16'h0041);
    idle(1);
    chk("R4 write 0 without read keeps flag", {15'b0, irq[0]}, 16'h0001);
    rd(3'd0, d); chk("R4 write 1 no effect", {15'b0, d[7]}, 16'h0001);
    pin_i[0] = 1'b0;
    idle(5);
    pin_i[0] = 1'b1;
    idle(5);
    wr(3'd0, 16'h0041);
    idle(1);
    chk("R4 event between read and write", {15'b0, irq[0]}, 16'h0001);
    rd(3'd0, d);
    wr(3'd0, 16'h0041);
    idle(1);
    chk("R5 irq drops after clear", {15'b0, irq[0]}, 16'h0000);
    rd(3'd0, d); chk("R4 cleared control byte", d, 16'h0041);

    // Compare operation (R6)
    wr(3'd1, 16'd10);
    wr(3'd0, 16'h0011);
    wr(3'd3, 16'd20);
    wr(3'd2, 16'h0012);
    idle(1);
    chk("R6 compare owns pins", {14'b0, pin_oe}, 16'h0003);
    chk("R6 levels before match", {14'b0, pin_o}, 16'h0003);
    cnt_clr = 1'b0;
    wait_cnt(16'd15);
    chk("R6 ch0 toggled at match", {15'b0, pin_o[0]}, 16'h0000);
    chk("R6 ch1 not yet matched", {15'b0, pin_o[1]}, 16'h0001);
    wait_cnt(16'd25);
    chk("R6 ch1 cleared at match", {15'b0, pin_o[1]}, 16'h0000);
    rd(3'd2, d); chk("R6 ch1 flag", {15'b0, d[7]}, 16'h0001);
    rd(3'd0, d); chk("R6 ch0 flag", {15'b0, d[7]}, 16'h0001);

    // Pin released, idle level from mode select (R8)
    cnt_clr = 1'b1;
    wr(3'd2, 16'h0010);
    idle(2);
    chk("R8 released pin enable", {15'b0, pin_oe[1]}, 16'h0000);
    chk("R8 mode 1 drives low", {15'b0, pin_o[1]}, 16'h0000);
    wr(3'd2, 16'h0000);
    idle(2);
    chk("R8 mode 0 drives high", {15'b0, pin_o[1]}, 16'h0001);

    // Buffered compare (R9, R10, R7)
    wr(3'd1, 16'd100);
    rd(3'd0, d);
    wr(3'd0, 16'h0023);
    rd(3'd2, d); chk("R9 ch1 ctrl reads zero", d, 16'h0000);
    wr(3'd2, 16'h0043);
    rd(3'd2, d); chk("R9 ch1 ctrl write ignored", d, 16'h0000);
    chk("R9 ch1 irq quiet", {15'b0, irq[1]}, 16'h0000);
    chk("R9 pin ownership", {14'b0, pin_oe}, 16'h0001);
    cnt_clr = 1'b0;
    wait_cnt(16'd150);
    chk("R9 buffered match sets output", {15'b0, pin_o[0]}, 16'h0001);
    wr(3'd3, 16'd300);
    wait_cnt(16'd150);
    chk("R7 overflow drives low, R10 old value retired", {15'b0, pin_o[0]}, 16'h0000);
    wait_cnt(16'd350);
    chk("R10 new compare value in force", {15'b0, pin_o[0]}, 16'h0001);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule